// File: doc/BRIEF.md
# Crossbar Fanout Read-Write Controller

This block is the sequencing state machine of an in-memory processing unit built on a resistive crossbar. It accepts three kinds of work while idle: a plain memory read, a plain memory write, and a logic-execution run made of a series of micro-operations. During a run, the micro-operation logic may flag that a result cell must feed several following gates. The controller then leaves execution, senses the driving cell for one cycle, and writes that sensed bit to every target line in a single parallel write cycle. After that it goes back to execution. This replaces a chain of double-inversion copies.

A policy input selects how a fanout is finished. In the skip-on-one policy, the copy targets are assumed to be preset to 1. A sensed 1 therefore needs no write, and the controller returns to execution straight after sensing. In the write-always policy, the targets hold unknown values, so the sensed bit is always written. The policy is captured when a run is accepted. Two counters report the fanouts handled and the writes skipped, so the cycles spent outside execution can be checked against the counts.

Top module: `xfc_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller goes to the idle state: `state` = 0, `ready` = 1, `wr_en` = 0, `rd_en` = 0, and both counters are 0.
- R2: The `state` encoding is idle = 0, sense = 1, drive = 2, execute = 3. In idle, `ready` is 1. A request moves the controller at the next edge, with the priority read (to 1), then write (to 2), then execute (to 3). Outside idle, `ready` is 0 and requests are ignored.
- R3: A plain read stays in state 1 with `rd_en` = 1 until `rd_done`. A plain write stays in state 2 with `wr_en` = 1, and with `wr_mask`/`wr_data` equal to `tgt_mask`/`wdata_in` as captured at acceptance, until `wr_done`. Both then return to idle.
- R4: Execution stays in state 3 until `ex_done`, then returns to idle. When `ex_done` and `fanout_evt` are both high in the same cycle, `ex_done` wins and no fanout is counted.
- R5: A `fanout_evt` in state 3 moves the controller to state 1 for exactly one cycle with `rd_en` = 1. It also captures `tgt_mask` and adds 1 to `fanout_cnt`.
- R6: Under the skip-on-one policy, a `sense_bit` of 1 in that sense cycle returns the controller to state 3 at the next edge. No `wr_en` pulse is produced and `skip_cnt` rises by 1.
- R7: Otherwise (write-always policy, or a sensed 0), the controller spends exactly one cycle in state 2 with `wr_en` = 1, `wr_mask` = the captured mask and `wr_data` = the sensed bit, then returns to state 3. A fanout thus costs one cycle outside execution when skipped and two when not.
- R8: `policy_skip1` = 1 selects skip-on-one and 0 selects write-always. The value is captured when an execute request is accepted, and changes during the run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Plain read request |
| req_wr | input | 1 | Plain write request |
| req_ex | input | 1 | Execution run request |
| policy_skip1 | input | 1 | 1 = skip-on-one, 0 = write-always |
| tgt_mask | input | LINES | Target lines for a write or fanout |
| wdata_in | input | 1 | Data bit for a plain write |
| rd_done | input | 1 | Plain read finished |
| wr_done | input | 1 | Plain write finished |
| ex_done | input | 1 | Execution run finished |
| fanout_evt | input | 1 | Current micro-operation has a fanout |
| sense_bit | input | 1 | Sensed value of the driving cell |
| ready | output | 1 | Controller idle, request accepted |
| state | output | 2 | Current state code |
| rd_en | output | 1 | Sense phase active |
| wr_en | output | 1 | Write phase active |
| wr_mask | output | LINES | Lines written in parallel |
| wr_data | output | 1 | Bit written to all masked lines |
| fanout_cnt | output | CNT_W | Fanouts handled |
| skip_cnt | output | CNT_W | Writes skipped |

## Verification
The hardest case to reach from the ports is one fanout landing in each combination of policy, sensed value and target mask inside a single execution run. Each of these must be paired with the exact count of cycles spent outside execution. The stimulus therefore opens one run per policy, and toggles the policy input right after acceptance to show that only the captured value is used. Within the run it fires a fanout for every mask of a small four-line configuration and for both sensed values. It times every excursion from state 3 and compares the per-run total with the arithmetic sum of one or two cycles per fanout. The ex_done-versus-fanout collision and requests presented while busy are driven on purpose at the cycles where they conflict.

// File: rtl/xfc_pkg.sv
// Package: shared state encoding for the crossbar fanout controller.
// Assumes a two-bit state code observed at the top-level port.
package xfc_pkg;
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_SENSE = 2'd1,
        XS_DRIVE = 2'd2,
        XS_EXEC  = 2'd3
    } xfc_state_e;
endpackage

// File: rtl/xfc_seq_fsm.sv
// Module: four-state sequencer. Serves plain reads, plain writes and
// execution runs, and diverts a run through sense/drive on a fanout.
// Assumes request inputs are sampled only while idle; fanout sense and
// drive phases each last exactly one cycle.
module xfc_seq_fsm
    import xfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_rd,
    input  logic       req_wr,
    input  logic       req_ex,
    input  logic       policy_skip1,
    input  logic       rd_done,
    input  logic       wr_done,
    input  logic       ex_done,
    input  logic       fanout_evt,
    input  logic       sense_bit,
    output xfc_state_e state_q,
    output logic       fo_active,
    output logic       mode_lat,
    output logic       take_req,
    output logic       take_wdata,
    output logic       take_fanout,
    output logic       take_sense,
    output logic       take_skip
);
    xfc_state_e state_d;
    logic       fo_d;
    logic       mode_d;

    // Strobes that tell the datapath and counters what happens this cycle.
    always_comb begin
        take_req    = (state_q == XS_IDLE) && (req_rd || req_wr || req_ex);
        take_wdata  = (state_q == XS_IDLE) && !req_rd && req_wr;
        take_fanout = (state_q == XS_EXEC) && !ex_done && fanout_evt;
        take_sense  = (state_q == XS_SENSE) && fo_active;
        take_skip   = take_sense && mode_lat && sense_bit;
    end

    // Next-state, fanout-flag and policy-latch decision.
    always_comb begin
        state_d = state_q;
        fo_d    = fo_active;
        mode_d  = mode_lat;
        unique case (state_q)
            XS_IDLE: begin
                fo_d = 1'b0;
                if (req_rd)      state_d = XS_SENSE;
                else if (req_wr) state_d = XS_DRIVE;
                else if (req_ex) begin
                    state_d = XS_EXEC;
                    mode_d  = policy_skip1;
                end
            end
            XS_SENSE: begin
                if (fo_active) begin
                    state_d = (mode_lat && sense_bit) ? XS_EXEC : XS_DRIVE;
                    if (mode_lat && sense_bit) fo_d = 1'b0;
                end else if (rd_done) begin
                    state_d = XS_IDLE;
                end
            end
            XS_DRIVE: begin
                if (fo_active) begin
                    state_d = XS_EXEC;
                    fo_d    = 1'b0;
                end else if (wr_done) begin
                    state_d = XS_IDLE;
                end
            end
            XS_EXEC: begin
                if (ex_done) begin
                    state_d = XS_IDLE;
                end else if (fanout_evt) begin
                    state_d = XS_SENSE;
                    fo_d    = 1'b1;
                end
            end
            default: state_d = XS_IDLE;
        endcase
    end

    // State, fanout flag and captured policy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= XS_IDLE;
            fo_active <= 1'b0;
            mode_lat  <= 1'b0;
        end else begin
            state_q   <= state_d;
            fo_active <= fo_d;
            mode_lat  <= mode_d;
        end
    end
endmodule

// File: rtl/xfc_write_latch.sv
// Module: holds the target mask and the bit to be written, and gates
// them onto the crossbar write lines during the drive phase.
// Assumes the sequencer raises at most one capture strobe per cycle
// for each register.
module xfc_write_latch
    import xfc_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfc_state_e       state_q,
    input  logic             take_req,
    input  logic             take_wdata,
    input  logic             take_fanout,
    input  logic             take_sense,
    input  logic [LINES-1:0] tgt_mask,
    input  logic             wdata_in,
    input  logic             sense_bit,
    output logic             rd_en,
    output logic             wr_en,
    output logic [LINES-1:0] wr_mask,
    output logic             wr_data
);
    localparam logic [LINES-1:0] NO_LINES = '0;

    logic [LINES-1:0] mask_q;
    logic             data_q;

    // Capture targets on request/fanout acceptance and data on write or sense.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= NO_LINES;
            data_q <= 1'b0;
        end else begin
            if (take_req || take_fanout) mask_q <= tgt_mask;
            if (take_wdata)              data_q <= wdata_in;
            else if (take_sense)         data_q <= sense_bit;
        end
    end

    // Phase enables and masked write lines.
    always_comb begin
        rd_en   = (state_q == XS_SENSE);
        wr_en   = (state_q == XS_DRIVE);
        wr_mask = wr_en ? mask_q : NO_LINES;
        wr_data = data_q;
    end
endmodule

// File: rtl/xfc_event_counter.sv
// Module: wrapping event counter, one step per strobe.
// Assumes the strobe is a single-cycle pulse per event.
module xfc_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count strobes modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + ONE;
    end
endmodule

// File: rtl/xfc_top.sv
// Module: crossbar fanout read-write controller top. Connects the
// sequencer, the write latch and the two event counters.
// Assumes the crossbar reports plain read/write completion and the
// execution engine reports run completion and fanout events.
module xfc_top
    import xfc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_rd,
    input  logic             req_wr,
    input  logic             req_ex,
    input  logic             policy_skip1,
    input  logic [LINES-1:0] tgt_mask,
    input  logic             wdata_in,
    input  logic             rd_done,
    input  logic             wr_done,
    input  logic             ex_done,
    input  logic             fanout_evt,
    input  logic             sense_bit,
    output logic             ready,
    output logic [1:0]       state,
    output logic             rd_en,
    output logic             wr_en,
    output logic [LINES-1:0] wr_mask,
    output logic             wr_data,
    output logic [CNT_W-1:0] fanout_cnt,
    output logic [CNT_W-1:0] skip_cnt
);
    xfc_state_e state_q;
    logic fo_active, mode_lat;
    logic take_req, take_wdata, take_fanout, take_sense, take_skip;

    xfc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_rd(req_rd), .req_wr(req_wr), .req_ex(req_ex),
        .policy_skip1(policy_skip1),
        .rd_done(rd_done), .wr_done(wr_done), .ex_done(ex_done),
        .fanout_evt(fanout_evt), .sense_bit(sense_bit),
        .state_q(state_q), .fo_active(fo_active), .mode_lat(mode_lat),
        .take_req(take_req), .take_wdata(take_wdata),
        .take_fanout(take_fanout), .take_sense(take_sense),
        .take_skip(take_skip)
    );

    xfc_write_latch #(.LINES(LINES)) u_wlat (
        .clk(clk), .rst_n(rst_n), .state_q(state_q),
        .take_req(take_req), .take_wdata(take_wdata),
        .take_fanout(take_fanout), .take_sense(take_sense),
        .tgt_mask(tgt_mask), .wdata_in(wdata_in), .sense_bit(sense_bit),
        .rd_en(rd_en), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data)
    );

    xfc_event_counter #(.CNT_W(CNT_W)) u_fo_cnt (
        .clk(clk), .rst_n(rst_n), .inc(take_fanout), .cnt(fanout_cnt)
    );

    xfc_event_counter #(.CNT_W(CNT_W)) u_skip_cnt (
        .clk(clk), .rst_n(rst_n), .inc(take_skip), .cnt(skip_cnt)
    );

    // Port view of the state and the idle handshake.
    always_comb begin
        state = state_q;
        ready = (state_q == XS_IDLE);
    end
endmodule

// File: rtl/xfc_checker.sv
// Module: temporal properties of the fanout controller, bound to xfc_top.
// Assumes internal fanout flag and captured policy are reachable by name.
module xfc_checker #(
    parameter int LINES = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_rd,
    input logic             req_wr,
    input logic             req_ex,
    input logic             ex_done,
    input logic             sense_bit,
    input logic             ready,
    input logic [1:0]       state,
    input logic             wr_en,
    input logic [LINES-1:0] wr_mask,
    input logic [CNT_W-1:0] fanout_cnt,
    input logic             fo_active,
    input logic             mode_lat
);
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !req_rd && !req_wr && !req_ex) |=> ready);

    p_write_not_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ready);

    p_mask_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && $past(state == 2'd2)) |-> $stable(wr_mask));

    p_done_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3 && ex_done) |=> (state == 2'd0));

    p_sense_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && fo_active) |=> (state != 2'd1));

    p_fanout_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fanout_cnt == $past(fanout_cnt)) || (fanout_cnt == $past(fanout_cnt) + CNT_W'(1)));

    p_skip_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && fo_active && mode_lat && sense_bit) |=> (state == 2'd3 && !wr_en));

    p_drive_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && fo_active) |=> (state == 2'd3));
endmodule

bind xfc_top xfc_checker #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_ex(req_ex), .ex_done(ex_done), .sense_bit(sense_bit),
    .ready(ready), .state(state), .wr_en(wr_en), .wr_mask(wr_mask),
    .fanout_cnt(fanout_cnt), .fo_active(fo_active), .mode_lat(mode_lat)
);

// File: tb/xfc_top_tb_top.sv
// Bench: sweeps every mask, sensed value and policy of a four-line
// configuration, and checks phase order and cycle costs arithmetically.
module xfc_top_tb_top;
    localparam int LINES = 4;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic req_rd, req_wr, req_ex, policy_skip1, wdata_in;
    logic rd_done, wr_done, ex_done, fanout_evt, sense_bit;
    logic [LINES-1:0] tgt_mask;
    logic ready, rd_en, wr_en, wr_data;
    logic [1:0] state;
    logic [LINES-1:0] wr_mask;
    logic [CNT_W-1:0] fanout_cnt, skip_cnt;

    int n_run = 0;
    int n_fail = 0;
    int exp_fo = 0;
    int exp_skip = 0;

    always #10 clk = ~clk;

    xfc_top #(.LINES(LINES), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_ex(req_ex), .policy_skip1(policy_skip1), .tgt_mask(tgt_mask),
        .wdata_in(wdata_in), .rd_done(rd_done), .wr_done(wr_done),
        .ex_done(ex_done), .fanout_evt(fanout_evt), .sense_bit(sense_bit),
        .ready(ready), .state(state), .rd_en(rd_en), .wr_en(wr_en),
        .wr_mask(wr_mask), .wr_data(wr_data), .fanout_cnt(fanout_cnt),
        .skip_cnt(skip_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One fanout while executing; returns cycles spent outside state 3.
    task automatic do_fanout(input int m, input bit s, input bit pol, output int cyc);
        fanout_evt = 1'b1;
        tgt_mask   = LINES'(m);
        @(negedge clk);
        fanout_evt = 1'b0;
        tgt_mask   = ~LINES'(m);
        exp_fo++;
        chk(state == 2'd1 && rd_en, "R5 sense state", state, 1);
        chk(int'(fanout_cnt) == exp_fo, "R5 fanout_cnt", fanout_cnt, exp_fo);
        sense_bit = s;
        cyc = 1;
        @(negedge clk);
        if (pol && s) begin
            exp_skip++;
            chk(state == 2'd3 && !wr_en, "R6 skip to exec", state, 3);
            chk(int'(skip_cnt) == exp_skip, "R6 skip_cnt", skip_cnt, exp_skip);
        end else begin
            cyc++;
            chk(state == 2'd2 && wr_en, "R7 drive state", state, 2);
            chk(int'(wr_mask) == m, "R7 wr_mask", wr_mask, m);
            chk(wr_data == s, "R7 wr_data", wr_data, s);
            @(negedge clk);
            chk(state == 2'd3 && !wr_en, "R7 back to exec", state, 3);
        end
        sense_bit = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        int tot;
        rst_n = 1'b0;
        {req_rd, req_wr, req_ex, policy_skip1, wdata_in} = '0;
        {rd_done, wr_done, ex_done, fanout_evt, sense_bit} = '0;
        tgt_mask = '0;
        repeat (3) @(negedge clk);
        chk(state == 2'd0 && ready && !wr_en && !rd_en, "R1 reset state", state, 0);
        chk(fanout_cnt == 0 && skip_cnt == 0, "R1 counters", fanout_cnt + skip_cnt, 0);
        rst_n = 1'b1;

        // R2 priority: read wins over write and execute.
        {req_rd, req_wr, req_ex} = 3'b111;
        @(negedge clk);
        {req_rd, req_wr, req_ex} = 3'b000;
        chk(state == 2'd1 && !ready && rd_en, "R2 read priority", state, 1);
        req_wr = 1'b1;
        repeat (2) @(negedge clk);
        chk(state == 2'd1, "R2 busy ignores request", state, 1);
        req_wr = 1'b0;
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk(state == 2'd0 && ready, "R3 read done", state, 0);

        // R2 write over execute, R3 plain write held until done.
        {req_wr, req_ex} = 2'b11;
        tgt_mask = 4'b1010;
        wdata_in = 1'b1;
        @(negedge clk);
        {req_wr, req_ex} = 2'b00;
        tgt_mask = 4'b0101;
        wdata_in = 1'b0;
        chk(state == 2'd2, "R2 write priority", state, 2);
        repeat (3) @(negedge clk);
        chk(wr_en && wr_mask == 4'b1010, "R3 write mask held", wr_mask, 10);
        chk(wr_data == 1'b1, "R3 write data held", wr_data, 1);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        chk(state == 2'd0 && !wr_en, "R3 write done", state, 0);

        // Policy sweep: one run per policy, every mask, both sensed bits.
        for (int pol = 0; pol < 2; pol++) begin
            policy_skip1 = pol[0];
            req_ex = 1'b1;
            @(negedge clk);
            req_ex = 1'b0;
            policy_skip1 = ~pol[0];
            chk(state == 2'd3 && !ready, "R2 execute accepted", state, 3);
            repeat (2) @(negedge clk);
            chk(state == 2'd3, "R4 execute held", state, 3);
            tot = 0;
            for (int m = 0; m < (1 << LINES); m++) begin
                for (int s = 0; s < 2; s++) begin
                    do_fanout(m, s[0], pol[0], cyc);
                    tot += cyc;
                end
            end
            chk(tot == (1 << LINES) * (pol ? 3 : 4), "R8 policy cycle total",
                tot, (1 << LINES) * (pol ? 3 : 4));
            policy_skip1 = 1'b0;
            ex_done = 1'b1;
            fanout_evt = 1'b1;
            @(negedge clk);
            ex_done = 1'b0;
            fanout_evt = 1'b0;
            chk(state == 2'd0, "R4 done beats fanout", state, 0);
            chk(int'(fanout_cnt) == exp_fo, "R4 no fanout counted", fanout_cnt, exp_fo);
        end

        chk(int'(skip_cnt) == (1 << LINES), "R6 total skips", skip_cnt, 1 << LINES);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule